// File: doc/BRIEF.md
# Maskable Minute/Hour/Day Alarm Unit

This block watches a running calendar and raises an alarm flag when the current time agrees with three programmed alarm registers: one for the minute, one for the hour, and one that holds either a set of weekdays or a calendar date. Each alarm register carries a wildcard bit in its top position. When that bit is set, the field always agrees with the current time. A mode bit in the control register decides how the third register is read. In weekday mode it is a mask that may select several days. In date mode it is a BCD date.

The calendar counters and the serial bus sit outside this block. The current minute, hour, one-hot weekday and date arrive on input ports, together with a one-cycle pulse that marks the moment the seconds roll over to 00. The comparison is made only on that pulse, so each matching minute sets the flag once. Software writes the alarm registers and the control register through a simple byte-wide write port and reads them back through a combinational read port. It clears the flag by writing 0 to bit 0 of the flag register. An active-low interrupt output is asserted while both the flag and the interrupt enable are 1.

Top module: `rtc_alarm_unit`

## Requirements
- R1: Register map for writes and reads: address 0 holds the alarm minute byte, address 1 the alarm hour byte, address 2 the alarm day byte, address 3 the control byte, and address 4 the flag. All 8 bits of addresses 0 to 2 are stored and read back unchanged, including hour bit 6, which is storage only. In the control byte, bit 0 is the day mode and bit 1 is the interrupt enable; the other control bits read 0. Address 4 reads the flag in bit 0.
- R2: The minute field agrees with the current time when bit 7 of the alarm minute byte is 1, or when its bits 6:0 equal the current BCD minute.
- R3: The hour field agrees when bit 7 of the alarm hour byte is 1, or when its bits 5:0 equal the current BCD hour. Bit 6 has no effect on the comparison.
- R4: The day field agrees when bit 7 of the alarm day byte is 1. Otherwise the mode bit decides. With mode 0, the field agrees when any of bits 6:0 is set at the same position as the one-hot current weekday (bit 0 = first day through bit 6 = seventh). With mode 1, the field agrees when bits 5:0 equal the current BCD date.
- R5: The flag becomes 1 on the clock edge at which `minute_tick` is high and all three fields agree. Without `minute_tick`, the flag is never set.
- R6: Once set, the flag stays set. A write to address 4 with data bit 0 = 0 clears it. A write with data bit 0 = 1 leaves it unchanged.
- R7: When a clear write and a setting tick fall on the same edge, the flag ends up set.
- R8: `irq_n` is 0 exactly while the flag and the interrupt enable are both 1.
- R9: After reset, all alarm and control bytes read 0, the flag is 0 and `irq_n` is 1.
- R10: On a tick, the comparison uses the register contents held before any write made on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| minute_tick | input | 1 | One-cycle pulse when the seconds roll to 00 |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_wday | input | 7 | Current weekday, one-hot |
| cur_date | input | 6 | Current date, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
Two pairs of events can land on the same edge. A software clear of the flag can coincide with a matching minute tick, and a write to an alarm register can coincide with a tick that compares against that register. The bench drives each pair in a single cycle, both with a tick that sets the flag and with one that does not. It then judges the result against R7 (the set wins) and R10 (the comparison uses the old contents). A behavioural reference model, compared every clock, covers the flag, the interrupt and the read port through all other sequences.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_MIN  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_HOUR = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_DAY  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd4;

    typedef struct packed {
        logic [REG_W-1:0] alm_min;
        logic [REG_W-1:0] alm_hour;
        logic [REG_W-1:0] alm_day;
        logic             mode;
        logic             ie;
        logic             flag;
    } alarm_state_t;
endpackage

// File: rtl/rtc_alarm_field_cmp.sv
module rtc_alarm_field_cmp #(
    parameter int VAL_W = 7
) (
    input  logic             wild,
    input  logic [VAL_W-1:0] alarm_val,
    input  logic [VAL_W-1:0] cur_val,
    output logic             ok
);
    assign ok = wild | (alarm_val == cur_val);
endmodule

// File: rtl/rtc_alarm_day_cmp.sv
module rtc_alarm_day_cmp #(
    parameter int WDAY_W = 7,
    parameter int DATE_W = 6
) (
    input  logic              wild,
    input  logic              date_mode,
    input  logic [WDAY_W-1:0] alarm_val,
    input  logic [WDAY_W-1:0] cur_wday,
    input  logic [DATE_W-1:0] cur_date,
    output logic              ok
);
    logic wday_hit;
    logic date_hit;

    assign wday_hit = |(alarm_val & cur_wday);
    assign date_hit = (alarm_val[DATE_W-1:0] == cur_date);
    assign ok       = wild | (date_mode ? date_hit : wday_hit);
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_alarm_pkg::*;
#(
    parameter int MIN_W  = 7,
    parameter int HOUR_W = 6,
    parameter int WDAY_W = 7,
    parameter int DATE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              minute_tick,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [WDAY_W-1:0] cur_wday,
    input  logic [DATE_W-1:0] cur_date,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              alarm_flag,
    output logic              irq_n
);
    localparam int WILD_BIT = REG_W - 1;

    alarm_state_t s_d, s_q;
    logic min_ok, hour_ok, day_ok, hit;

    rtc_alarm_field_cmp #(.VAL_W(MIN_W)) u_min_cmp (
        .wild      (s_q.alm_min[WILD_BIT]),
        .alarm_val (s_q.alm_min[MIN_W-1:0]),
        .cur_val   (cur_min),
        .ok        (min_ok)
    );

    rtc_alarm_field_cmp #(.VAL_W(HOUR_W)) u_hour_cmp (
        .wild      (s_q.alm_hour[WILD_BIT]),
        .alarm_val (s_q.alm_hour[HOUR_W-1:0]),
        .cur_val   (cur_hour),
        .ok        (hour_ok)
    );

    rtc_alarm_day_cmp #(.WDAY_W(WDAY_W), .DATE_W(DATE_W)) u_day_cmp (
        .wild      (s_q.alm_day[WILD_BIT]),
        .date_mode (s_q.mode),
        .alarm_val (s_q.alm_day[WDAY_W-1:0]),
        .cur_wday  (cur_wday),
        .cur_date  (cur_date),
        .ok        (day_ok)
    );

    assign hit = min_ok & hour_ok & day_ok;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_MIN:  s_d.alm_min  = wr_data;
                ADDR_HOUR: s_d.alm_hour = wr_data;
                ADDR_DAY:  s_d.alm_day  = wr_data;
                ADDR_CTRL: begin
                    s_d.mode = wr_data[0];
                    s_d.ie   = wr_data[1];
                end
                ADDR_FLAG: if (!wr_data[0]) s_d.flag = 1'b0;
                default: ;
            endcase
        end
        // a setting tick outranks a same-edge clear (R7)
        if (minute_tick && hit) s_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (rd_addr)
            ADDR_MIN:  rd_data = s_q.alm_min;
            ADDR_HOUR: rd_data = s_q.alm_hour;
            ADDR_DAY:  rd_data = s_q.alm_day;
            ADDR_CTRL: rd_data = {{(REG_W-2){1'b0}}, s_q.ie, s_q.mode};
            ADDR_FLAG: rd_data = {{(REG_W-1){1'b0}}, s_q.flag};
            default:   rd_data = '0;
        endcase
    end

    assign alarm_flag = s_q.flag;
    assign irq_n      = ~(s_q.flag & s_q.ie);
endmodule

// File: rtl/rtc_alarm_unit_chk.sv
module rtc_alarm_unit_chk
    import rtc_alarm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              minute_tick,
    input logic              hit,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              clr_bit,
    input logic              alarm_flag,
    input logic              irq_n
);
    logic clr_req;
    assign clr_req = wr_en && (wr_addr == ADDR_FLAG) && !clr_bit;

    AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (minute_tick && hit) |=> alarm_flag); // R5

    AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_flag && !minute_tick) |=> !alarm_flag); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !clr_req) |=> alarm_flag); // R6

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(minute_tick && hit)) |=> !alarm_flag); // R6

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && minute_tick && hit) |=> alarm_flag); // R7

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_flag |-> irq_n); // R8
endmodule

bind rtc_alarm_unit rtc_alarm_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .minute_tick (minute_tick),
    .hit         (hit),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .clr_bit     (wr_data[0]),
    .alarm_flag  (alarm_flag),
    .irq_n       (irq_n)
);

// File: tb/rtc_alarm_unit_tb.sv
`timescale 1ns/1ps
module rtc_alarm_unit_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       minute_tick = 0;
    logic [6:0] cur_min = 0;
    logic [5:0] cur_hour = 0;
    logic [6:0] cur_wday = 7'h01;
    logic [5:0] cur_date = 6'h01;
    logic       wr_en = 0;
    logic [2:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic [2:0] rd_addr = 3'd4;
    logic [7:0] rd_data;
    logic       alarm_flag, irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_min = 0, m_hour = 0, m_day = 0;
    logic       m_mode = 0, m_ie = 0, m_flag = 0;

    always #2 clk = ~clk;

    rtc_alarm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .minute_tick(minute_tick),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday), .cur_date(cur_date),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_min;
            3'd1: return m_hour;
            3'd2: return m_day;
            3'd3: return {6'b0, m_ie, m_mode};
            3'd4: return {7'b0, m_flag};
            default: return 8'h00;
        endcase
    endfunction

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        logic mok, hok, dok, match;
        if (!rst_n) begin
            m_min = 0; m_hour = 0; m_day = 0; m_mode = 0; m_ie = 0; m_flag = 0;
        end else begin
            mok = m_min[7] || (m_min[6:0] == cur_min);
            hok = m_hour[7] || (m_hour[5:0] == cur_hour);
            if (m_day[7])    dok = 1;
            else if (m_mode) dok = (m_day[5:0] == cur_date);
            else             dok = ((m_day[6:0] & cur_wday) != 0);
            match = mok && hok && dok;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_min  = wr_data;
                    3'd1: m_hour = wr_data;
                    3'd2: m_day  = wr_data;
                    3'd3: begin m_mode = wr_data[0]; m_ie = wr_data[1]; end
                    3'd4: if (wr_data[0] == 0) m_flag = 0;
                    default: ;
                endcase
            end
            if (minute_tick && match) m_flag = 1;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 flag vs model", {7'b0, alarm_flag}, {7'b0, m_flag});
            chk("R8 irq vs model", {7'b0, irq_n}, {7'b0, ~(m_flag & m_ie)});
            chk("R1 read vs model", rd_data, model_rd(rd_addr));
        end
    end

    task automatic step(input bit t, input bit w, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        minute_tick = t; wr_en = w; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        minute_tick = 0; wr_en = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        step(0, 1, a, d);
    endtask

    task automatic tick();
        step(1, 0, 3'd0, 8'h00);
    endtask

    task automatic set_time(input logic [6:0] mn, input logic [5:0] hr,
                            input logic [6:0] wd, input logic [5:0] dt);
        cur_min = mn; cur_hour = hr; cur_wday = wd; cur_date = dt;
    endtask

    task automatic clear_flag();
        wr(3'd4, 8'h00);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state observed while reset is held
        chk("R9 flag at reset", {7'b0, alarm_flag}, 8'h00);
        chk("R9 irq_n at reset", {7'b0, irq_n}, 8'h01);
        #1 rd_addr = 3'd0;
        @(negedge clk);
        chk("R9 alarm minute at reset", rd_data, 8'h00);
        #1 rd_addr = 3'd4; rst_n = 1;

        // basic match, weekday mode
        set_time(7'h30, 6'h12, 7'h04, 6'h15);
        wr(3'd0, 8'h30); wr(3'd1, 8'h12); wr(3'd2, 8'h04); wr(3'd3, 8'h02);
        tick();
        chk("R5 flag after matching tick", {7'b0, alarm_flag}, 8'h01);
        chk("R8 irq_n low with flag and enable", {7'b0, irq_n}, 8'h00);

        // R6 sticky flag and clear
        wr(3'd4, 8'h01);
        chk("R6 write 1 keeps flag", {7'b0, alarm_flag}, 8'h01);
        clear_flag();
        chk("R6 write 0 clears flag", {7'b0, alarm_flag}, 8'h00);
        chk("R8 irq_n released after clear", {7'b0, irq_n}, 8'h01);

        // R5 no tick, no set
        step(0, 0, 3'd0, 8'h00);
        step(0, 0, 3'd0, 8'h00);
        chk("R5 no tick leaves flag clear", {7'b0, alarm_flag}, 8'h00);

        // R2 minute compare and wildcard
        set_time(7'h31, 6'h12, 7'h04, 6'h15);
        tick();
        chk("R2 minute mismatch", {7'b0, alarm_flag}, 8'h00);
        wr(3'd0, 8'h80);
        set_time(7'h45, 6'h12, 7'h04, 6'h15);
        tick();
        chk("R2 minute wildcard", {7'b0, alarm_flag}, 8'h01);
        clear_flag();

        // R3 hour compare, wildcard, dummy bit 6
        wr(3'd0, 8'h30);
        set_time(7'h30, 6'h13, 7'h04, 6'h15);
        tick();
        chk("R3 hour mismatch", {7'b0, alarm_flag}, 8'h00);
        wr(3'd1, 8'h92);
        tick();
        chk("R3 hour wildcard", {7'b0, alarm_flag}, 8'h01);
        clear_flag();
        wr(3'd1, 8'h52);
        set_time(7'h30, 6'h12, 7'h04, 6'h15);
        tick();
        chk("R3 bit 6 ignored in compare", {7'b0, alarm_flag}, 8'h01);
        clear_flag();
        #1 rd_addr = 3'd1;
        @(negedge clk);
        chk("R1 hour bit 6 stored", rd_data, 8'h52);
        #1 rd_addr = 3'd4;

        // R4 weekday mask, date mode, day wildcard
        wr(3'd2, 8'h41);
        set_time(7'h30, 6'h12, 7'h40, 6'h15);
        tick();
        chk("R4 weekday mask hit", {7'b0, alarm_flag}, 8'h01);
        clear_flag();
        set_time(7'h30, 6'h12, 7'h02, 6'h15);
        tick();
        chk("R4 weekday mask miss", {7'b0, alarm_flag}, 8'h00);
        wr(3'd3, 8'h03);
        wr(3'd2, 8'h15);
        tick();
        chk("R4 date match", {7'b0, alarm_flag}, 8'h01);
        clear_flag();
        set_time(7'h30, 6'h12, 7'h02, 6'h16);
        tick();
        chk("R4 date mismatch", {7'b0, alarm_flag}, 8'h00);
        wr(3'd2, 8'h80);
        tick();
        chk("R4 day wildcard", {7'b0, alarm_flag}, 8'h01);

        // R7 same-edge clear and setting tick
        step(1, 1, 3'd4, 8'h00);
        chk("R7 set beats clear", {7'b0, alarm_flag}, 8'h01);

        // R8 interrupt disabled with flag set
        wr(3'd3, 8'h01);
        chk("R8 irq_n high when disabled", {7'b0, irq_n}, 8'h01);
        chk("R8 flag still set", {7'b0, alarm_flag}, 8'h01);
        clear_flag();
        wr(3'd3, 8'h03);

        // R10 same-edge register write uses old contents
        step(1, 1, 3'd0, 8'h31);
        chk("R10 old minute matched", {7'b0, alarm_flag}, 8'h01);
        clear_flag();
        step(1, 1, 3'd0, 8'h30);
        chk("R10 old minute mismatched", {7'b0, alarm_flag}, 8'h00);
        tick();
        chk("R10 new minute now matches", {7'b0, alarm_flag}, 8'h01);
        #1 rd_addr = 3'd3;
        @(negedge clk);
        chk("R1 control readback", rd_data, 8'h03);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule